// File: doc/BRIEF.md
# Cross-Partition Multicast Fan-Out Router

This block forwards multicast transaction packets from one partition of a packet switch to egress ports that belong to other partitions. It accepts a packet header (group ID, address, requester ID). It looks up the egress-port mask that software has programmed for that group, and keeps only the ports whose multicast transmit enable is set. It then offers the header to each selected port over a valid/ready handshake. Upstream is released only after every selected port has taken the packet.

Each egress port can rewrite the header on its own copy. An address overlay replaces the address bits at and above a per-port size with a per-port base. A requester-ID overlay replaces the 16-bit requester ID with a per-port value. Each overlay has its own enable, and the rewrite belongs to the port regardless of what functions the port hosts. Software programs the block through a single-cycle write port. Masks naming ports in the receiving partition are outside the intended use and produce unspecified fan-out. In that case the block still completes the packet.

Top module: `mcast_fanout_router`

## Requirements
- R1: Group IDs 0 to 3 use the mask register at config address equal to the group ID, with bit p selecting egress port p. In the cycle after a header is captured, outValid equals that mask ANDed with the transmit-enable vector. Later mask writes affect only later packets.
- R2: A packet whose group ID is 4 or above raises no outValid and is completed as a drop.
- R3: A packet whose effective port set is empty is dropped silently: no outValid, and inReady is high in the cycle after capture.
- R4: Bit 0 of the per-port control register (config address 4+4p) is the transmit enable. A port with this bit clear never raises outValid, even when its group mask selects it.
- R5: Bits 3 and 4 of the per-port control register (memory-access and bus-master command enables) have no effect on forwarding or rewriting.
- R6: Each selected port keeps outValid high and its outputs stable until it sees outReady. Ports accept independently and in any order.
- R7: inReady rises for exactly one cycle, in the cycle after the last selected port accepts. While any port is still pending, inReady stays low.
- R8: When bit 1 of the control register is set, outAddr for that port takes bits at and above the size (config address 4+4p+1, bits 5:0) from the base (config address 4+4p+2). Bits below the size come from the packet. When bit 1 is clear, the packet address passes unchanged.
- R9: When bit 2 of the control register is set, outRid for that port is the value at config address 4+4p+3, bits 15:0. When bit 2 is clear, outRid is the packet requester ID.
- R10: The address and requester-ID overlays are independent per port. Neither, either or both may apply on any port, and the combinations may differ between ports.
- R11: After reset, all masks, enables and overlay registers are zero, outValid is zero and inReady is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW (5) | Configuration register address |
| cfgData | input | ADDR_W (64) | Configuration write data |
| inValid | input | 1 | Upstream header valid; held until inReady |
| inReady | output | 1 | Packet completed (forwarded or dropped) |
| inGroup | input | GID_W (8) | Multicast group ID |
| inAddr | input | ADDR_W (64) | Packet address |
| inRid | input | RID_W (16) | Packet requester ID |
| outValid | output | NUM_PORTS (4) | Per-port send strobe |
| outReady | input | NUM_PORTS (4) | Per-port accept |
| outAddr | output | NUM_PORTS*ADDR_W (256) | Per-port address after overlay, port p at bits p*64 and up |
| outRid | output | NUM_PORTS*RID_W (64) | Per-port requester ID after overlay, port p at bits p*16 and up |

## Verification
The programmed groups cover four mask shapes: one port, two ports, all ports, and none. Together they separate the lookup from the transmit-enable gating. Group IDs above the supported range show that a drop comes from the range check and not from an empty mask. The port overlays are set to none, address only, requester ID only, and both. A single all-port packet then shows that each rewrite is selected per port and not shared. A staggered accept with a stalled port separates per-port completion from the upstream release.

// File: rtl/mcast_fanout_pkg.sv
package mcast_fanout_pkg;
  localparam int NUM_GROUPS = 4;
  localparam int REGS_PER_PORT = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } fanState_e;

  // Control to datapath strobes
  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/mcast_fanout_ctrl.sv
module mcast_fanout_ctrl
  import mcast_fanout_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [NUM_PORTS-1:0] sendVec,
  input  logic [NUM_PORTS-1:0] outReady,
  output logic [NUM_PORTS-1:0] outValid,
  output logic                 inReady,
  output ctrlStrobes_t         strobes
);
  fanState_e state;
  logic [NUM_PORTS-1:0] pending;

  always_comb begin
    strobes.capture = (state == ST_IDLE) && inValid;
    inReady = (state == ST_SEND) && (pending == '0);
    outValid = (state == ST_SEND) ? pending : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pending <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobes.capture) begin
          pending <= sendVec;
          state <= ST_SEND;
        end
        ST_SEND: begin
          if (pending == '0) state <= ST_IDLE;
          pending <= pending & ~outReady;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // An empty effective set is finished in the very next cycle
  assert_empty_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && sendVec == '0) |=> inReady);

  // Release upstream is a single-cycle pulse
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hold
    assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[p] && !outReady[p]) |=> outValid[p]);
  end
endmodule

// File: rtl/mcast_fanout_datapath.sv
module mcast_fanout_datapath
  import mcast_fanout_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 64,
  parameter int RID_W     = 16,
  parameter int GID_W     = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic                        cfgWrEn,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [ADDR_W-1:0]           cfgData,
  input  logic [GID_W-1:0]            inGroup,
  input  logic [ADDR_W-1:0]           inAddr,
  input  logic [RID_W-1:0]            inRid,
  output logic [NUM_PORTS-1:0]        sendVec,
  output logic [NUM_PORTS-1:0]        txEnVec,
  output logic [NUM_PORTS*ADDR_W-1:0] outAddr,
  output logic [NUM_PORTS*RID_W-1:0]  outRid
);
  localparam int SIZE_W = $clog2(ADDR_W);
  localparam int GIDX_W = $clog2(NUM_GROUPS);

  logic [NUM_PORTS-1:0] groupMask [NUM_GROUPS];
  logic [ADDR_W-1:0]    hdrAddr;
  logic [RID_W-1:0]     hdrRid;

  // Group mask registers
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN) groupMask[g] <= '0;
      else if (cfgWrEn && cfgAddr == CFG_AW'(g)) groupMask[g] <= cfgData[NUM_PORTS-1:0];
    end
  end

  // Group lookup gated by per-port transmit enable
  always_comb begin
    if (inGroup < GID_W'(NUM_GROUPS)) sendVec = groupMask[inGroup[GIDX_W-1:0]] & txEnVec;
    else sendVec = '0;
  end

  // Header latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrAddr <= '0;
      hdrRid <= '0;
    end else if (strobes.capture) begin
      hdrAddr <= inAddr;
      hdrRid <= inRid;
    end
  end

  // Per-port egress registers and overlays
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int BASE = NUM_GROUPS + REGS_PER_PORT * p;
    logic              addrOvlEn, ridOvlEn;
    logic [SIZE_W-1:0] ovlSize;
    logic [ADDR_W-1:0] ovlBase;
    logic [RID_W-1:0]  ovlRid;
    logic [ADDR_W-1:0] upperMask;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txEnVec[p] <= 1'b0;
        addrOvlEn <= 1'b0;
        ridOvlEn <= 1'b0;
        ovlSize <= '0;
        ovlBase <= '0;
        ovlRid <= '0;
      end else if (cfgWrEn) begin
        // Command-enable bits 4:3 are deliberately not stored
        if (cfgAddr == CFG_AW'(BASE)) begin
          txEnVec[p] <= cfgData[0];
          addrOvlEn <= cfgData[1];
          ridOvlEn <= cfgData[2];
        end
        if (cfgAddr == CFG_AW'(BASE + 1)) ovlSize <= cfgData[SIZE_W-1:0];
        if (cfgAddr == CFG_AW'(BASE + 2)) ovlBase <= cfgData;
        if (cfgAddr == CFG_AW'(BASE + 3)) ovlRid <= cfgData[RID_W-1:0];
      end
    end

    always_comb begin
      upperMask = {ADDR_W{1'b1}} << ovlSize;
      outAddr[p*ADDR_W +: ADDR_W] = addrOvlEn ? ((ovlBase & upperMask) | (hdrAddr & ~upperMask))
                                              : hdrAddr;
      outRid[p*RID_W +: RID_W] = ridOvlEn ? ovlRid : hdrRid;
    end
  end
endmodule

// File: rtl/mcast_fanout_router.sv
module mcast_fanout_router
  import mcast_fanout_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 64,
  parameter int RID_W     = 16,
  parameter int GID_W     = 8,
  parameter int CFG_AW    = $clog2(NUM_GROUPS + REGS_PER_PORT * NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [ADDR_W-1:0]           cfgData,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [GID_W-1:0]            inGroup,
  input  logic [ADDR_W-1:0]           inAddr,
  input  logic [RID_W-1:0]            inRid,
  output logic [NUM_PORTS-1:0]        outValid,
  input  logic [NUM_PORTS-1:0]        outReady,
  output logic [NUM_PORTS*ADDR_W-1:0] outAddr,
  output logic [NUM_PORTS*RID_W-1:0]  outRid
);
  ctrlStrobes_t         strobes;
  logic [NUM_PORTS-1:0] sendVec;
  logic [NUM_PORTS-1:0] txEnVec;

  mcast_fanout_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sendVec(sendVec),
    .outReady(outReady), .outValid(outValid), .inReady(inReady), .strobes(strobes)
  );

  mcast_fanout_datapath #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .RID_W(RID_W), .GID_W(GID_W), .CFG_AW(CFG_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inGroup(inGroup), .inAddr(inAddr), .inRid(inRid),
    .sendVec(sendVec), .txEnVec(txEnVec), .outAddr(outAddr), .outRid(outRid)
  );

  // Ports without transmit enable at capture never get a strobe
  assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ((outValid & ~$past(txEnVec)) == '0));

  // Out-of-range groups are never fanned out
  assert_range_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && inGroup >= GID_W'(NUM_GROUPS)) |=> (outValid == '0));
endmodule

// File: tb/mcast_fanout_router_bench.sv
module mcast_fanout_router_bench;
  localparam int NP = 4;
  localparam int AW = 64;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [AW-1:0] cfgData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inGroup = '0;
  logic [AW-1:0] inAddr = '0;
  logic [RW-1:0] inRid = '0;
  logic [NP-1:0] outValid;
  logic [NP-1:0] outReady = '0;
  logic [NP*AW-1:0] outAddr;
  logic [NP*RW-1:0] outRid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench-side model of the programmed overlay state
  bit addrEn [NP];
  bit ridEn [NP];
  int sizeReg [NP];
  logic [AW-1:0] baseReg [NP];
  logic [RW-1:0] ridReg [NP];

  always #5 clk = ~clk;

  mcast_fanout_router u_mcast_fanout_router (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inGroup(inGroup), .inAddr(inAddr), .inRid(inRid),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outRid(outRid)
  );

  typedef struct packed {
    logic [7:0]    grp;
    logic [AW-1:0] addr;
    logic [RW-1:0] rid;
    logic [NP-1:0] expVec;
  } vec_t;

  // Masks: g0=0001 g1=0110 g2=1111 g3=0000; port 3 transmit disabled
  localparam vec_t VECS [7] = '{
    '{8'd0, 64'h0123_4567_89AB_CDEF, 16'h1111, 4'b0001},
    '{8'd1, 64'hFEDC_BA98_7654_3210, 16'h2222, 4'b0110},
    '{8'd2, 64'h0000_1111_2222_3333, 16'h3333, 4'b0111},
    '{8'd3, 64'h4444_5555_6666_7777, 16'h4444, 4'b0000},
    '{8'd4, 64'h8888_9999_AAAA_BBBB, 16'h5555, 4'b0000},
    '{8'd200, 64'hCCCC_DDDD_EEEE_FFFF, 16'h6666, 4'b0000},
    '{8'd1, 64'h1357_9BDF_2468_ACE0, 16'h7777, 4'b0110}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expAddr(input int p, input logic [AW-1:0] a);
    logic [AW-1:0] hi;
    if (!addrEn[p]) return a;
    hi = {AW{1'b1}} << sizeReg[p];
    return (baseReg[p] & hi) | (a & ~hi);
  endfunction

  function automatic logic [RW-1:0] expRid(input int p, input logic [RW-1:0] r);
    return ridEn[p] ? ridReg[p] : r;
  endfunction

  task automatic cfgWrite(input int a, input logic [AW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = 5'(a);
    cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setPort(input int p, input logic [4:0] ctl, input int sz,
                         input logic [AW-1:0] base, input logic [RW-1:0] rid);
    cfgWrite(4 + 4*p, {59'd0, ctl});
    cfgWrite(4 + 4*p + 1, 64'(sz));
    cfgWrite(4 + 4*p + 2, base);
    cfgWrite(4 + 4*p + 3, {48'd0, rid});
    addrEn[p] = ctl[1];
    ridEn[p] = ctl[2];
    sizeReg[p] = sz;
    baseReg[p] = base;
    ridReg[p] = rid;
  endtask

  task automatic checkData(input logic [NP-1:0] vec, input logic [AW-1:0] a,
                           input logic [RW-1:0] r, input string req);
    for (int p = 0; p < NP; p++) begin
      if (vec[p]) begin
        chk(outAddr[p*AW +: AW] == expAddr(p, a), req, $sformatf("outAddr port %0d", p),
            outAddr[p*AW +: AW], expAddr(p, a));
        chk(outRid[p*RW +: RW] == expRid(p, r), req, $sformatf("outRid port %0d", p),
            64'(outRid[p*RW +: RW]), 64'(expRid(p, r)));
      end
    end
  endtask

  task automatic runPkt(input logic [7:0] g, input logic [AW-1:0] a, input logic [RW-1:0] r,
                        input logic [NP-1:0] expVec, input string req);
    @(negedge clk);
    inValid = 1'b1;
    inGroup = g;
    inAddr = a;
    inRid = r;
    outReady = '0;
    @(negedge clk);
    chk(outValid == expVec, req, "outValid after capture", 64'(outValid), 64'(expVec));
    chk(inReady == (expVec == '0), req, "inReady after capture", 64'(inReady),
        64'(expVec == '0));
    checkData(expVec, a, r, req);
    if (expVec != '0) begin
      outReady = '1;
      @(negedge clk);
      outReady = '0;
      chk(outValid == '0 && inReady, "R7", "release after accept",
          64'({inReady, outValid}), 64'h10);
    end
    @(negedge clk);
    inValid = 1'b0;
    chk(!inReady, "R7", "inReady pulse ends", 64'(inReady), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      addrEn[p] = 0; ridEn[p] = 0; sizeReg[p] = 0; baseReg[p] = '0; ridReg[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(outValid == '0 && !inReady, "R11", "reset outputs", 64'({inReady, outValid}), 64'd0);
    rstN = 1'b1;
    // R11: reset masks are zero, so group 0 is dropped
    runPkt(8'd0, 64'hDEAD, 16'hAAAA, 4'b0000, "R11");

    cfgWrite(0, 64'h1);
    cfgWrite(1, 64'h6);
    cfgWrite(2, 64'hF);
    cfgWrite(3, 64'h0);
    // ctl bits: 0 tx, 1 addr overlay, 2 rid overlay, 3/4 command enables (R5)
    setPort(0, 5'b00001, 0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0BAD);
    setPort(1, 5'b11011, 12, 64'hAAAA_BBBB_CCCC_DFFF, 16'h0BAD);
    setPort(2, 5'b00101, 8, 64'hFFFF_0000_FFFF_0000, 16'hBEEF);
    setPort(3, 5'b11110, 20, 64'h1234_5678_9ABC_DEF0, 16'hCAFE);

    // R1, R2, R3, R4, R5, R8, R9 over the vector table
    for (int i = 0; i < 7; i++) begin
      runPkt(VECS[i].grp, VECS[i].addr, VECS[i].rid, VECS[i].expVec,
             VECS[i].grp > 3 ? "R2" : (VECS[i].expVec == '0 ? "R3" : "R1/R4/R5/R8/R9"));
    end

    // R10: enable port 3 with both overlays, all four combinations at once
    setPort(3, 5'b00111, 20, 64'h1234_5678_9ABC_DEF0, 16'hCAFE);
    runPkt(8'd2, 64'h0F0F_0F0F_0F0F_0F0F, 16'h9999, 4'b1111, "R10");

    // R6/R7: staggered accept on group 1 (ports 1 and 2)
    @(negedge clk);
    inValid = 1'b1; inGroup = 8'd1; inAddr = 64'h55; inRid = 16'h55; outReady = '0;
    @(negedge clk);
    outReady = 4'b0010;
    @(negedge clk);
    outReady = '0;
    chk(outValid == 4'b0100 && !inReady, "R6", "after port 1 accepts",
        64'({inReady, outValid}), 64'h04);
    checkData(4'b0100, 64'h55, 16'h55, "R6");
    @(negedge clk);
    chk(outValid == 4'b0100 && !inReady, "R7", "stalled port holds release",
        64'({inReady, outValid}), 64'h04);
    outReady = 4'b0100;
    @(negedge clk);
    outReady = '0;
    chk(outValid == '0 && inReady, "R7", "release after last accept",
        64'({inReady, outValid}), 64'h10);
    @(negedge clk);
    inValid = 1'b0;

    // R1: mask rewrite takes effect for the next packet
    cfgWrite(3, 64'h8);
    runPkt(8'd3, 64'h77, 16'h77, 4'b1000, "R1");

    // R4: clearing transmit enable (command enables set) blocks port 0
    setPort(0, 5'b11000, 0, 64'h0, 16'h0);
    runPkt(8'd0, 64'h88, 16'h88, 4'b0000, "R4");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule